// File: doc/BRIEF.md
# Bus Event Interrupt Latch

This block gathers event conditions from a parallel peripheral bus controller and holds each one in a sticky status bit. Some conditions are gated by the controller's mode first. A five-bit enable mask selects which held bits may drive a single interrupt line toward the host.

Each status bit stays set until software reads the status word. The read strobe clears every bit on the following clock edge, except a bit whose event arrives in the same cycle as the read. The bus reset input is a level, and only its rising edge counts as an event. A reselection counts only when reselection response is enabled. A disconnect counts only for an initiator, and only when it was not expected, unless low-level mode is on. A status bit is held even when its enable is clear, so software can poll it. The interrupt line is registered, so it changes one cycle after the status or the mask changes. None of the inputs or outputs carries streamed data, so every pin is a plain control or status pin with no back-pressure.

Top module: `bus_event_irq`

## Requirements
- R1: After reset, `stat_o`, `mask_o` and `irq_o` are all zero.
- R2: Status bit 4 (reselection) is set on a cycle where `reselect_i` and `resel_resp_en_i` are both high. When `resel_resp_en_i` is low, `reselect_i` sets nothing.
- R3: A high `gross_err_i` sets status bit 3 and a high `parity_err_i` sets status bit 0, in every combination of `initiator_i` and `low_level_i`.
- R4: A high `tgt_disc_i` sets status bit 2 only when `initiator_i` is high and `disc_expected_i` is low. In target mode (`initiator_i` low) no disconnect sets bit 2.
- R5: With `low_level_i` high and `initiator_i` high, a disconnect sets status bit 2 even when `disc_expected_i` is high.
- R6: Status bit 1 (bus reset) is set only on a rising edge of `bus_rst_i`. A level held high for many cycles raises it once; after a clear it stays clear until `bus_rst_i` falls and rises again.
- R7: A set status bit stays set until a cycle with `rd_stat_i` high. That read clears the bit on the next edge, unless its event is present in the same cycle as the read, in which case it stays set.
- R8: A cycle with `wr_mask_i` high loads `mask_wdata_i` into `mask_o`. The bit positions are: 4 reselection, 3 gross error, 2 unexpected disconnect, 1 bus reset, 0 parity. `irq_o` equals the OR of (`stat_o` AND `mask_o`) as it stood one cycle earlier.
- R9: A status bit is latched even when its mask bit is zero, and in that case it does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reselect_i | input | 1 | Reselection by another device detected |
| gross_err_i | input | 1 | Gross error event |
| tgt_disc_i | input | 1 | Connected target left the bus |
| bus_rst_i | input | 1 | Bus reset line level, from any driver |
| parity_err_i | input | 1 | Parity error on send or receive |
| initiator_i | input | 1 | 1 = initiator mode, 0 = target mode |
| low_level_i | input | 1 | Low-level mode: every disconnect is unexpected |
| resel_resp_en_i | input | 1 | Reselection response enabled |
| disc_expected_i | input | 1 | A disconnect is currently expected |
| rd_stat_i | input | 1 | Status read strobe; clears status bits on the next edge |
| stat_o | output | 5 | Held status bits |
| wr_mask_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 5 | Mask write data |
| mask_o | output | 5 | Current enable mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong internal state shows up on `stat_o` at the first negative edge after the clock edge that should have set or cleared a bit. It reaches `irq_o` one cycle after that. A stale bus reset edge register would show as a missing or repeated bit 1 on the first cycle the level is held. A mode gate that is wrong would show as bit 2 or bit 4 differing from the arithmetic value for one of the swept mode combinations. A broken mask or interrupt path would show in the full sweep of 32 status patterns against 32 masks, two cycles after each mask write.

// File: rtl/bus_event_pkg.sv
package bus_event_pkg;
  localparam int unsigned NUM_EVT  = 5;
  localparam int unsigned IDX_PAR  = 0;
  localparam int unsigned IDX_RST  = 1;
  localparam int unsigned IDX_DISC = 2;
  localparam int unsigned IDX_GERR = 3;
  localparam int unsigned IDX_RSEL = 4;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import bus_event_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reselect_i,
  input  logic     gross_err_i,
  input  logic     tgt_disc_i,
  input  logic     bus_rst_i,
  input  logic     parity_err_i,
  input  logic     initiator_i,
  input  logic     low_level_i,
  input  logic     resel_resp_en_i,
  input  logic     disc_expected_i,
  output evt_vec_t evt_o
);
  logic bus_rst_q;
  logic disc_unexp;

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rst_q <= 1'b0;
    else        bus_rst_q <= bus_rst_i;
  end

  assign disc_unexp = low_level_i | ~disc_expected_i;

  always_comb begin
    evt_o           = '0;
    evt_o[IDX_RSEL] = reselect_i & resel_resp_en_i;
    evt_o[IDX_GERR] = gross_err_i;
    evt_o[IDX_DISC] = tgt_disc_i & initiator_i & disc_unexp;
    evt_o[IDX_RST]  = bus_rst_i & ~bus_rst_q;
    evt_o[IDX_PAR]  = parity_err_i;
  end

  // R6: a level already high on the previous cycle is never a new event
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rst_i) |-> !evt_o[IDX_RST]);
  // R4: target mode never yields a disconnect event
  assert_disc_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !initiator_i |-> !evt_o[IDX_DISC]);
endmodule

// File: rtl/evt_status.sv
module evt_status
  import bus_event_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t evt_i,
  input  logic     rd_i,
  output evt_vec_t stat_o
);
  evt_vec_t stat_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        stat_q[g] <= 1'b0;
      else if (evt_i[g]) stat_q[g] <= 1'b1;
      else if (rd_i)     stat_q[g] <= 1'b0;
    end

    // R7: held without a read
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !rd_i) |=> stat_q[g]);
    // R7: a read with no coincident event clears
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !evt_i[g]) |=> !stat_q[g]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import bus_event_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t stat_i,
  input  logic     wr_i,
  input  evt_vec_t wdata_i,
  output evt_vec_t mask_o,
  output logic     irq_o
);
  evt_vec_t mask_q;
  logic     irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_i) mask_q <= wdata_i;
      irq_q <= |(stat_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R8: enabled pending status raises the line one cycle later
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_i & mask_o)) |=> irq_o);
  // R9: nothing enabled pending means the line is low next cycle
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_i & mask_o)) |=> !irq_o);
endmodule

// File: rtl/bus_event_irq.sv
module bus_event_irq
  import bus_event_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reselect_i,
  input  logic               gross_err_i,
  input  logic               tgt_disc_i,
  input  logic               bus_rst_i,
  input  logic               parity_err_i,
  input  logic               initiator_i,
  input  logic               low_level_i,
  input  logic               resel_resp_en_i,
  input  logic               disc_expected_i,
  input  logic               rd_stat_i,
  output logic [NUM_EVT-1:0] stat_o,
  input  logic               wr_mask_i,
  input  logic [NUM_EVT-1:0] mask_wdata_i,
  output logic [NUM_EVT-1:0] mask_o,
  output logic               irq_o
);
  evt_vec_t evt;

  evt_qualify u_qual (
    .clk, .rst_n, .reselect_i, .gross_err_i, .tgt_disc_i, .bus_rst_i,
    .parity_err_i, .initiator_i, .low_level_i, .resel_resp_en_i,
    .disc_expected_i, .evt_o(evt)
  );

  evt_status u_stat (
    .clk, .rst_n, .evt_i(evt), .rd_i(rd_stat_i), .stat_o
  );

  irq_gen u_irq (
    .clk, .rst_n, .stat_i(stat_o), .wr_i(wr_mask_i), .wdata_i(mask_wdata_i),
    .mask_o, .irq_o
  );

  // R2: reselection bit only appears after an enabled reselection
  assert_resel_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[IDX_RSEL]) |-> $past(reselect_i && resel_resp_en_i));
  // R4: disconnect bit only appears after an initiator-mode disconnect
  assert_disc_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[IDX_DISC]) |-> $past(tgt_disc_i && initiator_i));
  // R6: reset bit only appears after the line was high
  assert_rst_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[IDX_RST]) |-> $past(bus_rst_i));
endmodule

// File: tb/test_bus_event_irq.sv
module test_bus_event_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reselect_i = 0, gross_err_i = 0, tgt_disc_i = 0, bus_rst_i = 0;
  logic       parity_err_i = 0, initiator_i = 0, low_level_i = 0;
  logic       resel_resp_en_i = 0, disc_expected_i = 0, rd_stat_i = 0;
  logic       wr_mask_i = 0;
  logic [4:0] mask_wdata_i = '0;
  logic [4:0] stat_o, mask_o;
  logic       irq_o;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  bus_event_irq i_bus_event_irq (
    .clk, .rst_n, .reselect_i, .gross_err_i, .tgt_disc_i, .bus_rst_i,
    .parity_err_i, .initiator_i, .low_level_i, .resel_resp_en_i,
    .disc_expected_i, .rd_stat_i, .stat_o, .wr_mask_i, .mask_wdata_i,
    .mask_o, .irq_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_stat();
    rd_stat_i = 1; tick(); rd_stat_i = 0; tick();
  endtask

  task automatic write_mask(input logic [4:0] m);
    wr_mask_i = 1; mask_wdata_i = m; tick(); wr_mask_i = 0; tick();
  endtask

  task automatic set_pattern(input logic [4:0] s);
    clear_stat();
    initiator_i = 1; disc_expected_i = 0; resel_resp_en_i = 1;
    reselect_i = s[4]; gross_err_i = s[3]; tgt_disc_i = s[2];
    bus_rst_i = s[1]; parity_err_i = s[0];
    tick();
    reselect_i = 0; gross_err_i = 0; tgt_disc_i = 0; bus_rst_i = 0;
    parity_err_i = 0;
    tick();
  endtask

  initial begin
    tick(); tick();
    chk("R1 stat", stat_o, 0); chk("R1 mask", mask_o, 0); chk("R1 irq", irq_o, 0);
    rst_n = 1; tick();
    chk("R1 stat after release", stat_o, 0);

    // R2 reselection gate
    for (int en = 0; en < 2; en++) begin
      clear_stat();
      resel_resp_en_i = en[0]; reselect_i = 1; tick(); reselect_i = 0; tick();
      chk("R2 resel", stat_o, en ? 5'b10000 : 0);
    end

    // R3 gross error and parity in all modes
    for (int md = 0; md < 4; md++) begin
      initiator_i = md[0]; low_level_i = md[1];
      clear_stat();
      gross_err_i = 1; tick(); gross_err_i = 0; tick();
      chk("R3 gross", stat_o, 5'b01000);
      clear_stat();
      parity_err_i = 1; tick(); parity_err_i = 0; tick();
      chk("R3 parity", stat_o, 5'b00001);
    end

    // R4 / R5 disconnect qualification sweep
    for (int md = 0; md < 8; md++) begin
      int e;
      initiator_i = md[0]; low_level_i = md[1]; disc_expected_i = md[2];
      clear_stat();
      tgt_disc_i = 1; tick(); tgt_disc_i = 0; tick();
      e = (md[0] && (md[1] || !md[2])) ? 4 : 0;
      chk(md[1] ? "R5 low-level disc" : "R4 disc", stat_o, e);
    end
    low_level_i = 0; disc_expected_i = 0;

    // R6 bus reset edge
    clear_stat();
    bus_rst_i = 1; tick();
    chk("R6 first edge", stat_o, 5'b00010);
    rd_stat_i = 1; tick(); rd_stat_i = 0;
    for (int k = 0; k < 5; k++) tick();
    chk("R6 held level no repeat", stat_o, 0);
    bus_rst_i = 0; tick(); tick();
    chk("R6 fall no event", stat_o, 0);
    bus_rst_i = 1; tick(); bus_rst_i = 0; tick();
    chk("R6 second edge", stat_o, 5'b00010);

    // R7 sticky, clear on read, coincident event survives
    set_pattern(5'b01001);
    for (int k = 0; k < 4; k++) tick();
    chk("R7 sticky", stat_o, 5'b01001);
    rd_stat_i = 1; gross_err_i = 1;
    chk("R7 read value", stat_o, 5'b01001);
    tick(); rd_stat_i = 0; gross_err_i = 0; tick();
    chk("R7 coincident kept", stat_o, 5'b01000);
    clear_stat();
    chk("R7 cleared", stat_o, 0);

    // R8 / R9 sweep of status pattern vs mask
    for (int s = 0; s < 32; s++) begin
      set_pattern(s[4:0]);
      chk("R9 latched regardless of mask", stat_o, s);
      for (int m = 0; m < 32; m++) begin
        write_mask(m[4:0]);
        chk("R8 mask readback", mask_o, m);
        chk(((s & m) == 0) ? "R9 irq masked" : "R8 irq", irq_o, ((s & m) != 0) ? 1 : 0);
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) chk("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule